// File: doc/BRIEF.md
# Pixel Component Extractor

This block sits between a scan-out byte stream and the display output stage. Raw pixel bytes arrive one per cycle. The block packs them, least significant byte first, into a pixel word of one to four bytes. From that word it cuts a red, a green and a blue field, and scales each field to an 8-bit component. The position and width of each field are set at run time, so one datapath serves packed formats such as 3-3-2, 5-6-5, 8-8-8 and 10-10-10.

Each color channel has its own default value. The channel shows that value instead of extracted data in three cases: its field width is zero, the pixel lies outside the visible region, or any byte of the pixel arrived while the fetch buffer reported an underrun. Software sets up the formats through a small write port that has four word-wide registers. Setting the red default to full scale and the other defaults to zero makes every underrun show on screen as a red pixel.

Top module: `pixel_comp_extract`

## Requirements
- R1: After reset, `pix_vld` is low until a pixel completes. All select registers reset to zero and the format register resets to one byte per pixel, so the first pixel comes out as 0x00/0x00/0x00.
- R2: The format register is at address 0. Its bits 4:3 hold the byte count per pixel minus one. Exactly one output triple appears for each completed group of that many accepted bytes.
- R3: Bytes are packed little-endian. The first byte of a pixel lands in word bits 7:0, the second in bits 15:8, and so on. Word bits above the last byte of the pixel are zero.
- R4: The red, green and blue select registers are at addresses 1, 2 and 3. In each one, bits 4:0 give the lowest word bit of the field and bits 11:8 give the field width in bits.
- R5: A field narrower than 8 bits is placed at the top of the component, and its bits are repeated downward into the lower bits. A field of 8 or more bits gives its top 8 bits.
- R6: When a channel's width field is zero, that channel outputs its default value, held in bits 23:16 of its select register.
- R7: A pixel with any byte accepted while `vis_active` is low outputs the default value on all three channels.
- R8: A pixel with any byte accepted while `byte_underrun` is high outputs the default value on all three channels. With defaults of 0xFF/0x00/0x00, that pixel is pure red.
- R9: `pix_vld` rises on the clock edge right after the edge that accepts the last byte of a pixel, and is high for one cycle per pixel.
- R10: A write to the format register throws away any part-assembled pixel, so the next accepted byte starts a new pixel.
- R11: Field bits above word bit 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A pixel byte is present this cycle |
| byte_dat | input | 8 | Pixel byte |
| byte_underrun | input | 1 | The fetch buffer has run dry for this byte |
| vis_active | input | 1 | This byte belongs to the visible region |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 format, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Register write data |
| pix_vld | output | 1 | Output triple is valid |
| pix_r | output | 8 | Red component |
| pix_g | output | 8 | Green component |
| pix_b | output | 8 | Blue component |

## Verification
Pixels are pushed through each byte width from one to four, using packed layouts with fields narrower than, equal to and wider than eight bits. Single-channel patterns such as pure red or pure blue in 5-6-5 show that the fields are placed correctly and that bytes are packed in order. A field that sits at the top of the word shows the zero fill above bit 31. A zero-width channel, blanking and underrun (the last two also applied to only the first byte of a pixel) show the default paths apart from the extraction path. A partial pixel cut off by a format write shows the flush. Each output is also checked against the cycle its last byte entered.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int COMP_W   = 8;
  localparam int CFG_W    = 32;
  localparam int OFS_W    = 5;
  localparam int LEN_W    = 4;
  localparam int OFS_LO   = 0;
  localparam int LEN_LO   = 8;
  localparam int DFLT_LO  = 16;
  localparam int FMT_LO   = 3;
  localparam int N_CHAN   = 3;

  typedef struct packed {
    logic [COMP_W-1:0] dflt;
    logic [LEN_W-1:0]  len;
    logic [OFS_W-1:0]  ofs;
  } chan_sel_t;

  typedef enum logic [1:0] {
    A_FMT = 2'd0,
    A_RED = 2'd1,
    A_GRN = 2'd2,
    A_BLU = 2'd3
  } cfg_addr_e;

  // Top-align a field of 'len' bits into COMP_W bits, repeating its bits downward.
  function automatic logic [COMP_W-1:0] fit_component(input logic [31:0] fld,
                                                      input logic [LEN_W-1:0] len);
    logic [COMP_W-1:0] o;
    logic [4:0] idx;
    o = '0;
    if (len != '0) begin
      for (int k = 0; k < COMP_W; k++) begin
        idx = 5'(int'(len) - 1 - (k % int'(len)));
        o[COMP_W-1-k] = fld[idx];
      end
    end
    return o;
  endfunction
endpackage

// File: rtl/pxu_rst_sync.sv
module pxu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pxu_cfg_regs.sv
module pxu_cfg_regs
  import pxu_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [1:0]            addr,
  input  logic [CFG_W-1:0]      wdata,
  output logic [CNT_W-1:0]      bpp_m1,
  output chan_sel_t             sel [N_CHAN],
  output logic                  fmt_wr
);
  logic [CNT_W-1:0] bpp_m1_q, bpp_m1_d;
  logic             fmt_en;
  chan_sel_t        wsel;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[CFG_W-1:DFLT_LO+COMP_W],
                          wdata[DFLT_LO-1:LEN_LO+LEN_W],
                          wdata[LEN_LO-1:OFS_LO+OFS_W]};

  always_comb begin
    wsel.dflt = wdata[DFLT_LO +: COMP_W];
    wsel.len  = wdata[LEN_LO  +: LEN_W];
    wsel.ofs  = wdata[OFS_LO  +: OFS_W];
    fmt_en    = we && (cfg_addr_e'(addr) == A_FMT);
    bpp_m1_d  = wdata[FMT_LO +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bpp_m1_q <= '0;
    else if (fmt_en) bpp_m1_q <= bpp_m1_d;
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_sel
    chan_sel_t sel_q;
    logic      sel_en;
    always_comb sel_en = we && (addr == 2'(c + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_en) sel_q <= wsel;
    end
    assign sel[c] = sel_q;
  end

  assign bpp_m1 = bpp_m1_q;
  assign fmt_wr = fmt_en;
endmodule

// File: rtl/pxu_byte_pack.sv
module pxu_byte_pack #(
  parameter int MAX_BYTES = 4,
  parameter int CNT_W     = 2,
  localparam int WORD_W   = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_dat,
  input  logic              byte_underrun,
  input  logic              vis_active,
  input  logic [CNT_W-1:0]  bpp_m1,
  input  logic              flush,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              word_force
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              stk_q, stk_d;
  logic              take, bad, last;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q;
  logic              force_q, force_d;

  always_comb begin
    take  = byte_vld && !flush;
    bad   = byte_underrun || !vis_active;
    last  = take && (cnt_q == bpp_m1);
    acc_d = acc_q;
    if (take) begin
      if (cnt_q == '0) acc_d = '0;
      for (int b = 0; b < MAX_BYTES; b++) begin
        if (cnt_q == CNT_W'(b)) acc_d[b*8 +: 8] = byte_dat;
      end
    end
    cnt_d = cnt_q;
    stk_d = stk_q;
    if (flush) begin
      cnt_d = '0;
      stk_d = 1'b0;
    end else if (take) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
      stk_d = last ? 1'b0 : (stk_q || bad);
    end
    vld_d   = last;
    force_d = stk_q || bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      stk_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stk_q <= stk_d;
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      force_q <= 1'b0;
    end else if (last) begin
      word_q  <= acc_d;
      force_q <= force_d;
    end
  end

  assign word_vld   = vld_q;
  assign word       = word_q;
  assign word_force = force_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= bpp_m1);
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && !word_vld);
  p_one_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(byte_vld));
endmodule

// File: rtl/pxu_chan.sv
module pxu_chan
  import pxu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              force_dflt,
  input  chan_sel_t         sel,
  output logic [COMP_W-1:0] comp
);
  logic [COMP_W-1:0] comp_q, comp_d;
  logic [31:0]       fld;

  always_comb begin
    fld = 32'(word >> sel.ofs);
    if (force_dflt || sel.len == '0) comp_d = sel.dflt;
    else                              comp_d = fit_component(fld, sel.len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      comp_q <= '0;
    else if (in_vld) comp_q <= comp_d;
  end

  assign comp = comp_q;

  p_zero_len_dflt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sel.len == '0) |=> comp == $past(sel.dflt));
  p_force_dflt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && force_dflt) |=> comp == $past(sel.dflt));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(comp));
endmodule

// File: rtl/pixel_comp_extract.sv
module pixel_comp_extract
  import pxu_pkg::*;
#(
  parameter int MAX_BYTES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_dat,
  input  logic        byte_underrun,
  input  logic        vis_active,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        pix_vld,
  output logic [7:0]  pix_r,
  output logic [7:0]  pix_g,
  output logic [7:0]  pix_b
);
  localparam int CNT_W  = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int WORD_W = MAX_BYTES * 8;

  logic              srst_n;
  logic [CNT_W-1:0]  bpp_m1;
  chan_sel_t         sel [N_CHAN];
  logic              fmt_wr;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic              word_force;
  logic [COMP_W-1:0] comp [N_CHAN];
  logic              vld_q;

  pxu_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  pxu_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(srst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .bpp_m1(bpp_m1), .sel(sel), .fmt_wr(fmt_wr)
  );

  pxu_byte_pack #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_pack (
    .clk(clk), .rst_n(srst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_underrun(byte_underrun), .vis_active(vis_active), .bpp_m1(bpp_m1),
    .flush(fmt_wr), .word_vld(word_vld), .word(word), .word_force(word_force)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    pxu_chan #(.WORD_W(WORD_W)) u_chan (
      .clk(clk), .rst_n(srst_n), .in_vld(word_vld), .word(word),
      .force_dflt(word_force), .sel(sel[c]), .comp(comp[c])
    );
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) vld_q <= 1'b0;
    else         vld_q <= word_vld;
  end

  assign pix_vld = vld_q;
  assign pix_r   = comp[0];
  assign pix_g   = comp[1];
  assign pix_b   = comp[2];

  p_latency_r9: assert property (@(posedge clk) disable iff (!srst_n)
    word_vld |=> pix_vld);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!srst_n)
    pix_vld |-> $past(word_vld));
  p_fmt_flush_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (cfg_we && cfg_addr == 2'd0) |=> !word_vld);
endmodule

// File: tb/tb_pixel_comp_extract.sv
module tb_pixel_comp_extract;
  logic        clk;
  logic        rst_n;
  logic        byte_vld;
  logic [7:0]  byte_dat;
  logic        byte_underrun;
  logic        vis_active;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        pix_vld;
  logic [7:0]  pix_r, pix_g, pix_b;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  logic [23:0] exp_q[$];
  int          exp_cyc_q[$];
  string       tag_q[$];

  int          bpp;
  logic [4:0]  s_ofs [3];
  logic [3:0]  s_len [3];
  logic [7:0]  s_dflt [3];

  pixel_comp_extract dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .byte_underrun(byte_underrun), .vis_active(vis_active), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pix_vld(pix_vld),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
  );

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] ref_comp(input logic [31:0] w, input int ofs,
                                          input int len, input logic [7:0] dflt);
    logic [63:0] f, r;
    int tot;
    if (len == 0) return dflt;
    f = (64'(w) >> ofs) & ((64'd1 << len) - 1);
    r = f;
    tot = len;
    while (tot < 8) begin
      r = (r << len) | f;
      tot = tot + len;
    end
    return 8'(r >> (tot - 8));
  endfunction

  function automatic logic [23:0] ref_pix(input logic [31:0] w, input bit frc);
    logic [7:0] c [3];
    for (int i = 0; i < 3; i++)
      c[i] = frc ? s_dflt[i] : ref_comp(w, int'(s_ofs[i]), int'(s_len[i]), s_dflt[i]);
    return {c[0], c[1], c[2]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      byte_vld = 0;
      byte_underrun = 0;
      vis_active = 1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    idle(3);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a == 2'd0) bpp = int'(d[4:3]) + 1;
    else begin
      s_ofs[a-1]  = d[4:0];
      s_len[a-1]  = d[11:8];
      s_dflt[a-1] = d[23:16];
    end
  endtask

  function automatic logic [31:0] sel_word(input int ofs, input int len, input int dflt);
    return (32'(dflt) << 16) | (32'(len) << 8) | 32'(ofs);
  endfunction

  // bad_at: byte index carrying the fault (-1 none); kind 0 underrun, 1 blank
  task automatic put_px(input logic [31:0] w, input int bad_at, input int kind,
                        input string tag);
    logic [31:0] wm;
    wm = (bpp == 4) ? w : (w & ((32'd1 << (8 * bpp)) - 1));
    exp_q.push_back(ref_pix(wm, bad_at >= 0));
    tag_q.push_back(tag);
    for (int b = 0; b < bpp; b++) begin
      @(negedge clk);
      byte_vld = 1;
      byte_dat = w[b*8 +: 8];
      byte_underrun = (b == bad_at) && (kind == 0);
      vis_active = !((b == bad_at) && (kind == 1));
      if (b == bpp - 1) exp_cyc_q.push_back(cyc + 2);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && pix_vld) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected pixel", {8'h0, pix_r, pix_g, pix_b}, 32'h0);
      end else begin
        logic [23:0] e;
        int ec;
        string t;
        e = exp_q.pop_front();
        ec = exp_cyc_q.pop_front();
        t = tag_q.pop_front();
        check({pix_r, pix_g, pix_b} == e, t, {8'h0, pix_r, pix_g, pix_b}, {8'h0, e});
        check(cyc == ec, "R9 latency", cyc, ec);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0; byte_vld = 0; byte_dat = 0; byte_underrun = 0; vis_active = 1;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    bpp = 1;
    for (int i = 0; i < 3; i++) begin s_ofs[i] = 0; s_len[i] = 0; s_dflt[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: quiet after reset, zero config gives a black pixel
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(pix_vld == 0, "R1 idle valid", pix_vld, 0);
    end
    put_px(32'hAB, -1, 0, "R1 reset config");
    idle(4);

    // R2 R3 R4 R5: 5-6-5 two-byte pixels
    wr(2'd0, 32'd1 << 3);
    wr(2'd1, sel_word(11, 5, 0));
    wr(2'd2, sel_word(5, 6, 0));
    wr(2'd3, sel_word(0, 5, 0));
    put_px(32'hF800, -1, 0, "R3 565 red");
    put_px(32'h07E0, -1, 0, "R3 565 green");
    put_px(32'h001F, -1, 0, "R3 565 blue");
    put_px(32'hFFFF, -1, 0, "R5 565 white");
    put_px(32'h1234, -1, 0, "R4 565 mixed");
    idle(4);

    // R2 R3: 8-8-8 three-byte pixels
    wr(2'd0, 32'd2 << 3);
    wr(2'd1, sel_word(16, 8, 0));
    wr(2'd2, sel_word(8, 8, 0));
    wr(2'd3, sel_word(0, 8, 0));
    put_px(32'h00A1B2C3, -1, 0, "R3 888 order");
    put_px(32'h00FF0001, -1, 0, "R2 888 bytes");
    idle(4);

    // R5: 10-10-10 four-byte pixels, wider than 8 bits
    wr(2'd0, 32'd3 << 3);
    wr(2'd1, sel_word(22, 10, 0));
    wr(2'd2, sel_word(12, 10, 0));
    wr(2'd3, sel_word(2, 10, 0));
    put_px(32'hDEADBEEF, -1, 0, "R5 wide field");
    put_px(32'h3FF00C01, -1, 0, "R5 wide field b");
    // R11: field reaching past bit 31
    wr(2'd1, sel_word(28, 8, 0));
    put_px(32'hA0000000, -1, 0, "R11 top fill");
    idle(4);

    // R5: 3-3-2 one-byte pixels
    wr(2'd0, 32'd0);
    wr(2'd1, sel_word(5, 3, 0));
    wr(2'd2, sel_word(2, 3, 0));
    wr(2'd3, sel_word(0, 2, 0));
    put_px(32'hA5, -1, 0, "R5 332 replicate");
    put_px(32'h6B, -1, 0, "R5 332 replicate b");
    // R6: zero width on green shows its default
    wr(2'd2, sel_word(2, 0, 8'h5A));
    put_px(32'hFF, -1, 0, "R6 zero width");
    idle(4);

    // R7 R8: blanking and underrun, red defaults to full scale
    wr(2'd0, 32'd1 << 3);
    wr(2'd1, sel_word(11, 5, 8'hFF));
    wr(2'd2, sel_word(5, 6, 0));
    wr(2'd3, sel_word(0, 5, 0));
    put_px(32'h1234, 1, 1, "R7 blank last byte");
    put_px(32'h5678, 0, 1, "R7 blank first byte");
    put_px(32'h001F, 1, 0, "R8 underrun red");
    put_px(32'h07E0, 0, 0, "R8 underrun first byte");
    put_px(32'h07E0, -1, 0, "R8 clean after underrun");
    idle(4);

    // R10: format write discards a half pixel
    @(negedge clk);
    byte_vld = 1; byte_dat = 8'hEE; byte_underrun = 1; vis_active = 1;
    idle(2);
    wr(2'd0, 32'd1 << 3);
    put_px(32'h001F, -1, 0, "R10 flush");
    idle(6);

    check(exp_q.size() == 0, "R2 missing pixels", exp_q.size(), 0);
    finish_run();
  end
endmodule